// File: doc/BRIEF.md
# Multi-Context Accelerator Transaction Manager

This block keeps a small table of open neural-network jobs and feeds one shared compute backend from it. A host process opens a job by naming a network ID and giving the number of neurons that job must allocate. The block takes the lowest free table slot and hands back its index as the transaction ID. Every slot also records the address-space ID of the process that opened it. After that, the process marks its input stream complete and reads the job's result with the transaction ID it was given. Any access that carries a different address-space ID is turned away and returns no data.

Each cycle the arbiter looks at the slots that can make progress and picks one in round-robin order. For that slot it issues one backend command. A job whose network configuration is not yet resident gets a configuration load. A job whose configuration is resident and whose inputs are complete gets allocation of a processing element for its next neuron. Because several jobs are in the table at once, their commands interleave on the backend. A command stays on the backend port until the backend acknowledges it, and the table is updated only on that acknowledge.

Top module: `nn_txn_mgr`

## Requirements
- R1: An open request while at least one slot is free asserts `open_ok` in the same cycle, returns the lowest-numbered free slot on `open_tid`, and fills that slot on the next clock edge.
- R2: An open request while all slots are occupied asserts `open_busy`, deasserts `open_ok` and leaves the table unchanged.
- R3: An input or read access whose address-space ID differs from the one stored in the addressed slot is rejected: the reject flag is set, `rd_data` is zero, the input-complete state does not change and the slot is not freed.
- R4: The first backend command for a new job is a configuration load (`be_kind` = 0), carrying the job's slot, its network ID and neuron index 0. Exactly one configuration load is issued per job.
- R5: Neuron commands (`be_kind` = 1) for a job are issued only after its configuration load has been acknowledged and an accepted input access with `in_last` = 1 has been seen. They carry neuron indices 0, 1, ... up to the job's neuron count minus one, in that order.
- R6: While `be_valid` is high and `be_ack` is low, `be_valid`, `be_kind`, `be_tid`, `be_nnid` and `be_neuron` hold their values on the next cycle.
- R7: Among eligible slots, the arbiter grants the first one at or after the slot following the last grant, wrapping from the highest slot to slot 0.
- R8: After the acknowledge of its last neuron command, a job is done. A read from the owning address space then asserts `rd_ok`, returns the job's network ID on `rd_data`, and frees the slot, so that the slot can be allocated again.
- R9: After reset, no slot is valid, `be_valid` is low and the first grant goes to slot 0.
- R10: A read of a slot whose job is not yet done is rejected with `rd_data` equal to zero, even from the owning address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| open_valid | input | 1 | Request to open a job |
| open_asid | input | 4 | Address-space ID of the requester |
| open_nnid | input | 16 | Network ID to run |
| open_neurons | input | 8 | Number of neuron allocations the job needs |
| open_ok | output | 1 | Open accepted this cycle |
| open_busy | output | 1 | Open refused because the table is full |
| open_tid | output | 2 | Transaction ID given to an accepted open |
| in_valid | input | 1 | Input access for a job |
| in_tid | input | 2 | Transaction ID of the input access |
| in_asid | input | 4 | Address-space ID of the input access |
| in_last | input | 1 | This input access completes the job's inputs |
| in_reject | output | 1 | Input access refused |
| rd_valid | input | 1 | Result read request |
| rd_tid | input | 2 | Transaction ID of the read |
| rd_asid | input | 4 | Address-space ID of the read |
| rd_ok | output | 1 | Read accepted; the slot is freed |
| rd_reject | output | 1 | Read refused |
| rd_data | output | 16 | Network ID of the finished job, zero unless `rd_ok` is high |
| be_valid | output | 1 | Backend command pending |
| be_kind | output | 1 | 0 = configuration load, 1 = neuron allocation |
| be_tid | output | 2 | Slot the command serves |
| be_nnid | output | 16 | Network ID of that slot |
| be_neuron | output | 8 | Neuron index for an allocation |
| be_ack | input | 1 | Backend takes the pending command |

## Verification
The bench probes isolation by sending input and read accesses with the wrong address-space ID. A design that leaks would issue neuron commands for a job that never got its inputs, or would free the slot and return its network ID. It also reads a job before it is done, and it keeps the backend stalled while a fifth open arrives, to catch a design that hands out an occupied slot or changes a command before the acknowledge. The exact interleaving of four jobs with different neuron counts is compared item by item. A wrong round-robin start, a double configuration load or a neuron index that is skipped or repeated shows up as a mismatch in that sequence. Finally, a freed slot is reopened, which exposes a design that never releases finished slots.

// File: rtl/nn_txn_pkg.sv
// Shared definitions for the transaction manager.
// Assumes: backend commands come in exactly two kinds.
package nn_txn_pkg;
    typedef enum logic {
        CMD_CFG_LOAD = 1'b0,
        CMD_NEURON   = 1'b1
    } cmd_kind_e;
endpackage

// File: rtl/nn_txn_free_find.sv
// Finds the lowest-numbered unused table slot.
// Assumes: vld has one bit per slot; idx is meaningless when any is low.
module nn_txn_free_find #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     vld,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // scan from the top down so the lowest free slot wins
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (!vld[k]) begin
                any = 1'b1;
                idx = IDX_W'(k);
            end
        end
    end
endmodule

// File: rtl/nn_txn_rr_pick.sv
// Round-robin pick among eligible slots, starting the search at 'start'.
// Assumes: start < N; grant is meaningless when any is low.
module nn_txn_rr_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     elig,
    input  logic [IDX_W-1:0] start,
    output logic             any,
    output logic [IDX_W-1:0] grant
);
    // walk the slots once from start, wrapping, and keep the first hit
    always_comb begin
        any   = 1'b0;
        grant = '0;
        for (int k = 0; k < N; k++) begin
            int s;
            s = int'(start) + k;
            if (s >= N) s = s - N;
            if (!any && elig[s]) begin
                any   = 1'b1;
                grant = IDX_W'(s);
            end
        end
    end
endmodule

// File: rtl/nn_txn_cmd_reg.sv
// Holds one backend command from issue until the backend acknowledges it.
// Assumes: load is only raised while no command is pending.
module nn_txn_cmd_reg #(
    parameter int TID_W  = 2,
    parameter int NNID_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              ld_kind,
    input  logic [TID_W-1:0]  ld_tid,
    input  logic [NNID_W-1:0] ld_nnid,
    input  logic [CNT_W-1:0]  ld_neuron,
    input  logic              ack,
    output logic              be_valid,
    output logic              be_kind,
    output logic [TID_W-1:0]  be_tid,
    output logic [NNID_W-1:0] be_nnid,
    output logic [CNT_W-1:0]  be_neuron
);
    // capture on load, release on acknowledge, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            be_valid  <= 1'b0;
            be_kind   <= 1'b0;
            be_tid    <= '0;
            be_nnid   <= '0;
            be_neuron <= '0;
        end else if (load && !be_valid) begin
            be_valid  <= 1'b1;
            be_kind   <= ld_kind;
            be_tid    <= ld_tid;
            be_nnid   <= ld_nnid;
            be_neuron <= ld_neuron;
        end else if (be_valid && ack) begin
            be_valid  <= 1'b0;
        end
    end

    // R6
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (be_valid && !ack) |=> (be_valid && $stable(be_kind) && $stable(be_tid)
                                && $stable(be_nnid) && $stable(be_neuron)));
endmodule

// File: rtl/nn_txn_mgr.sv
// Transaction table and arbiter in front of a shared neural-network backend.
// Opens jobs, tags them with the owner's address space, tracks config and
// neuron progress, and issues one backend command at a time in round-robin.
// Assumes: ENTRIES is a power of two; open_neurons fits CNT_W bits.
module nn_txn_mgr #(
    parameter int ENTRIES = 4,
    parameter int ASID_W  = 4,
    parameter int NNID_W  = 16,
    parameter int CNT_W   = 8,
    localparam int TID_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_valid,
    input  logic [ASID_W-1:0] open_asid,
    input  logic [NNID_W-1:0] open_nnid,
    input  logic [CNT_W-1:0]  open_neurons,
    output logic              open_ok,
    output logic              open_busy,
    output logic [TID_W-1:0]  open_tid,
    input  logic              in_valid,
    input  logic [TID_W-1:0]  in_tid,
    input  logic [ASID_W-1:0] in_asid,
    input  logic              in_last,
    output logic              in_reject,
    input  logic              rd_valid,
    input  logic [TID_W-1:0]  rd_tid,
    input  logic [ASID_W-1:0] rd_asid,
    output logic              rd_ok,
    output logic              rd_reject,
    output logic [NNID_W-1:0] rd_data,
    output logic              be_valid,
    output logic              be_kind,
    output logic [TID_W-1:0]  be_tid,
    output logic [NNID_W-1:0] be_nnid,
    output logic [CNT_W-1:0]  be_neuron,
    input  logic              be_ack
);
    import nn_txn_pkg::*;

    logic [ENTRIES-1:0] e_vld, e_cfg, e_inok, e_done, elig;
    logic [ASID_W-1:0]  e_asid  [ENTRIES];
    logic [NNID_W-1:0]  e_nnid  [ENTRIES];
    logic [CNT_W-1:0]   e_next  [ENTRIES];
    logic [CNT_W-1:0]   e_total [ENTRIES];

    logic             free_any, pick_any, issue, in_take, ack_hit;
    logic [TID_W-1:0] free_idx, pick_idx, rr_ptr;

    nn_txn_free_find #(.N(ENTRIES), .IDX_W(TID_W)) u_free (
        .vld(e_vld), .any(free_any), .idx(free_idx)
    );

    // a slot may use the backend when it needs config, or has inputs and neurons left
    always_comb begin
        for (int i = 0; i < ENTRIES; i++)
            elig[i] = e_vld[i] && !e_done[i] && (!e_cfg[i] || e_inok[i]);
    end

    nn_txn_rr_pick #(.N(ENTRIES), .IDX_W(TID_W)) u_pick (
        .elig(elig), .start(rr_ptr), .any(pick_any), .grant(pick_idx)
    );

    assign issue   = pick_any && !be_valid;
    assign ack_hit = be_valid && be_ack;

    nn_txn_cmd_reg #(.TID_W(TID_W), .NNID_W(NNID_W), .CNT_W(CNT_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .load(issue),
        .ld_kind(e_cfg[pick_idx] ? CMD_NEURON : CMD_CFG_LOAD),
        .ld_tid(pick_idx), .ld_nnid(e_nnid[pick_idx]), .ld_neuron(e_next[pick_idx]),
        .ack(be_ack), .be_valid(be_valid), .be_kind(be_kind), .be_tid(be_tid),
        .be_nnid(be_nnid), .be_neuron(be_neuron)
    );

    // host-side responses, decided in the cycle of the request
    always_comb begin
        open_ok   = open_valid && free_any;
        open_busy = open_valid && !free_any;
        open_tid  = free_any ? free_idx : '0;
        in_take   = in_valid && e_vld[in_tid] && !e_done[in_tid]
                    && (e_asid[in_tid] == in_asid);
        in_reject = in_valid && !in_take;
        rd_ok     = rd_valid && e_vld[rd_tid] && e_done[rd_tid]
                    && (e_asid[rd_tid] == rd_asid);
        rd_reject = rd_valid && !rd_ok;
        rd_data   = rd_ok ? e_nnid[rd_tid] : '0;
    end

    // round-robin pointer moves past each slot that is granted
    always_ff @(posedge clk) begin
        if (!rst_n)
            rr_ptr <= '0;
        else if (issue)
            rr_ptr <= (int'(pick_idx) == ENTRIES - 1) ? '0 : pick_idx + TID_W'(1);
    end

    // table update: open fills a slot; read, input and acknowledge touch live slots
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_vld  <= '0;
            e_cfg  <= '0;
            e_inok <= '0;
            e_done <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                e_asid[i]  <= '0;
                e_nnid[i]  <= '0;
                e_next[i]  <= '0;
                e_total[i] <= '0;
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (open_ok && free_idx == TID_W'(i)) begin
                    e_vld[i]   <= 1'b1;
                    e_cfg[i]   <= 1'b0;
                    e_inok[i]  <= 1'b0;
                    e_done[i]  <= 1'b0;
                    e_asid[i]  <= open_asid;
                    e_nnid[i]  <= open_nnid;
                    e_next[i]  <= '0;
                    e_total[i] <= open_neurons;
                end else begin
                    if (rd_ok && rd_tid == TID_W'(i))
                        e_vld[i] <= 1'b0;
                    if (in_take && in_last && in_tid == TID_W'(i))
                        e_inok[i] <= 1'b1;
                    if (ack_hit && be_tid == TID_W'(i)) begin
                        if (be_kind == CMD_CFG_LOAD) begin
                            e_cfg[i] <= 1'b1;
                            if (e_total[i] == '0) e_done[i] <= 1'b1;
                        end else begin
                            e_next[i] <= e_next[i] + CNT_W'(1);
                            if (e_next[i] + CNT_W'(1) == e_total[i]) e_done[i] <= 1'b1;
                        end
                    end
                end
            end
        end
    end

    // R1
    open_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_ok |-> !e_vld[open_tid]);
    // R2
    full_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_busy |-> (&e_vld));
    // R4
    cfg_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (be_valid && be_kind == CMD_CFG_LOAD) |-> (e_vld[be_tid] && !e_cfg[be_tid]));
    // R5
    alloc_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (be_valid && be_kind == CMD_NEURON) |->
            (e_cfg[be_tid] && e_inok[be_tid] && be_neuron < e_total[be_tid]));
    // R3
    iso_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && e_vld[rd_tid] && e_asid[rd_tid] != rd_asid) |=> e_vld[$past(rd_tid)]);
endmodule

// File: tb/nn_txn_mgr_bench.sv
// Scoreboard bench: driver tasks queue the expected backend commands, a
// backend model pops and compares them as the design issues them.
module nn_txn_mgr_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        open_valid = 1'b0, in_valid = 1'b0, in_last = 1'b0, rd_valid = 1'b0;
    logic [3:0]  open_asid = '0, in_asid = '0, rd_asid = '0;
    logic [15:0] open_nnid = '0;
    logic [7:0]  open_neurons = '0;
    logic [1:0]  in_tid = '0, rd_tid = '0;
    logic        be_ack = 1'b0;
    logic        open_ok, open_busy, in_reject, rd_ok, rd_reject;
    logic [1:0]  open_tid, be_tid;
    logic [15:0] rd_data, be_nnid;
    logic        be_valid, be_kind;
    logic [7:0]  be_neuron;

    int checks = 0;
    int fails  = 0;
    bit done_flag = 0;
    bit stall = 0;
    logic [26:0] sb[$];
    logic [26:0] held;
    bit          held_seen = 0;

    always #10 clk = ~clk;

    nn_txn_mgr u_nn_txn_mgr (
        .clk(clk), .rst_n(rst_n),
        .open_valid(open_valid), .open_asid(open_asid), .open_nnid(open_nnid),
        .open_neurons(open_neurons), .open_ok(open_ok), .open_busy(open_busy),
        .open_tid(open_tid), .in_valid(in_valid), .in_tid(in_tid), .in_asid(in_asid),
        .in_last(in_last), .in_reject(in_reject), .rd_valid(rd_valid), .rd_tid(rd_tid),
        .rd_asid(rd_asid), .rd_ok(rd_ok), .rd_reject(rd_reject), .rd_data(rd_data),
        .be_valid(be_valid), .be_kind(be_kind), .be_tid(be_tid), .be_nnid(be_nnid),
        .be_neuron(be_neuron), .be_ack(be_ack)
    );

    function automatic logic [26:0] cmd(input logic k, input logic [1:0] t,
                                        input logic [15:0] n, input logic [7:0] u);
        return {k, t, n, u};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_open(input logic [3:0] a, input logic [15:0] n, input logic [7:0] c,
                           input bit exp_ok, input logic [1:0] exp_tid, input string req);
        @(negedge clk);
        open_valid = 1; open_asid = a; open_nnid = n; open_neurons = c;
        #2;
        chk(open_ok == exp_ok && open_busy == !exp_ok, req, {open_ok, open_busy}, {exp_ok, !exp_ok});
        if (exp_ok) chk(open_tid == exp_tid, req, open_tid, exp_tid);
        @(negedge clk);
        open_valid = 0;
    endtask

    task automatic do_in(input logic [1:0] t, input logic [3:0] a, input bit exp_rej,
                         input string req);
        @(negedge clk);
        in_valid = 1; in_tid = t; in_asid = a; in_last = 1;
        #2;
        chk(in_reject == exp_rej, req, in_reject, exp_rej);
        @(negedge clk);
        in_valid = 0; in_last = 0;
    endtask

    task automatic do_rd(input logic [1:0] t, input logic [3:0] a, input bit exp_ok,
                         input logic [15:0] exp_d, input string req);
        @(negedge clk);
        rd_valid = 1; rd_tid = t; rd_asid = a;
        #2;
        chk(rd_ok == exp_ok && rd_reject == !exp_ok, req, {rd_ok, rd_reject}, {exp_ok, !exp_ok});
        chk(rd_data == exp_d, req, rd_data, exp_d);
        @(negedge clk);
        rd_valid = 0;
    endtask

    task automatic sb_empty(input string req);
        chk(sb.size() == 0, req, sb.size(), 0);
    endtask

    // backend model and monitor: compare each acknowledged command with the queue
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && be_valid) begin
                if (stall) begin
                    be_ack = 0;
                    if (held_seen)
                        chk(held == cmd(be_kind, be_tid, be_nnid, be_neuron), "R6",
                            {5'd0, cmd(be_kind, be_tid, be_nnid, be_neuron)}, {5'd0, held});
                    held = cmd(be_kind, be_tid, be_nnid, be_neuron);
                    held_seen = 1;
                end else begin
                    held_seen = 0;
                    be_ack = 1;
                    if (sb.size() == 0)
                        chk(0, "R4/R5/R7 unexpected command",
                            {5'd0, cmd(be_kind, be_tid, be_nnid, be_neuron)}, 0);
                    else begin
                        logic [26:0] e;
                        e = sb.pop_front();
                        chk(e == cmd(be_kind, be_tid, be_nnid, be_neuron), "R4/R5/R7 sequence",
                            {5'd0, cmd(be_kind, be_tid, be_nnid, be_neuron)}, {5'd0, e});
                    end
                end
            end else begin
                be_ack = 0;
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        chk(be_valid == 0, "R9", be_valid, 0);
        rst_n = 1;

        // R9, R1, R4: first open gets slot 0 and a config load
        sb.push_back(cmd(0, 2'd0, 16'h00A1, 8'd0));
        do_open(4'd1, 16'h00A1, 8'd2, 1, 2'd0, "R9/R1");
        repeat (6) @(negedge clk);
        sb_empty("R4");
        do_rd(2'd0, 4'd1, 0, 16'h0, "R10");
        do_in(2'd0, 4'd2, 1, "R3");
        repeat (8) @(negedge clk);
        sb_empty("R3 no neuron without inputs");

        // R5: neurons in order once inputs complete
        sb.push_back(cmd(1, 2'd0, 16'h00A1, 8'd0));
        sb.push_back(cmd(1, 2'd0, 16'h00A1, 8'd1));
        do_in(2'd0, 4'd1, 0, "R5");
        repeat (10) @(negedge clk);
        sb_empty("R5");

        // R3, R8: wrong owner refused, owner reads and frees
        do_rd(2'd0, 4'd2, 0, 16'h0, "R3");
        do_rd(2'd0, 4'd1, 1, 16'h00A1, "R8");
        do_rd(2'd0, 4'd1, 0, 16'h0, "R8 freed");

        // R6, R2, R7: fill the table with the backend stalled
        stall = 1;
        sb.push_back(cmd(0, 2'd0, 16'h00B0, 8'd0));
        do_open(4'd3, 16'h00B0, 8'd3, 1, 2'd0, "R8 reuse");
        do_open(4'd5, 16'h00B1, 8'd1, 1, 2'd1, "R1");
        do_open(4'd6, 16'h00B2, 8'd2, 1, 2'd2, "R1");
        do_open(4'd7, 16'h00B3, 8'd1, 1, 2'd3, "R1");
        do_open(4'd8, 16'h00FF, 8'd1, 0, 2'd0, "R2");
        do_in(2'd0, 4'd3, 0, "R5");
        do_in(2'd1, 4'd5, 0, "R5");
        do_in(2'd2, 4'd6, 0, "R5");
        do_in(2'd3, 4'd7, 0, "R5");
        repeat (4) @(negedge clk);
        sb.push_back(cmd(0, 2'd1, 16'h00B1, 8'd0));
        sb.push_back(cmd(0, 2'd2, 16'h00B2, 8'd0));
        sb.push_back(cmd(0, 2'd3, 16'h00B3, 8'd0));
        sb.push_back(cmd(1, 2'd0, 16'h00B0, 8'd0));
        sb.push_back(cmd(1, 2'd1, 16'h00B1, 8'd0));
        sb.push_back(cmd(1, 2'd2, 16'h00B2, 8'd0));
        sb.push_back(cmd(1, 2'd3, 16'h00B3, 8'd0));
        sb.push_back(cmd(1, 2'd0, 16'h00B0, 8'd1));
        sb.push_back(cmd(1, 2'd2, 16'h00B2, 8'd1));
        sb.push_back(cmd(1, 2'd0, 16'h00B0, 8'd2));
        stall = 0;
        repeat (40) @(negedge clk);
        sb_empty("R7");

        // R8: each owner collects its result
        do_rd(2'd1, 4'd5, 1, 16'h00B1, "R8");
        do_rd(2'd3, 4'd7, 1, 16'h00B3, "R8");
        do_rd(2'd2, 4'd6, 1, 16'h00B2, "R8");
        do_rd(2'd0, 4'd3, 1, 16'h00B0, "R8");
        sb.push_back(cmd(0, 2'd0, 16'h00C0, 8'd0));
        do_open(4'd9, 16'h00C0, 8'd1, 1, 2'd0, "R8 reuse");
        repeat (6) @(negedge clk);
        sb_empty("R4");

        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule